// File: doc/BRIEF.md
# Reset-Timeout Bus Clock Sequencer

After a power-on or low-voltage reset request, this block keeps the system bus clock phases parked and drives an active-low reset output. It releases both only after a fixed number of oscillator reference ticks has been counted. From then on it issues a one-cycle bus-clock enable strobe for every four ticks of the selected source. The source is either the oscillator tick or the PLL tick. A select input chooses between them, and both ticks arrive as single-cycle enables in one shared clock domain.

Sequencing logic elsewhere can start from a single-cycle release strobe. A new reset request at any moment restarts the whole timeout. A change of the source select is taken up only on a divide-by-four boundary, so that no bus cycle is cut short.

Top module: `bus_clk_seq`

## Requirements
- R1: After a reset request, `rst_n_out` stays low until exactly `TIMEOUT` (default 4096) `osc_tick` pulses have been sampled. It reads high in the cycle after the edge that samples the last of these pulses.
- R2: While `rst_n_out` is low, `bus_en` is 0.
- R3: When `rst`, `por_req` or `lvi_req` is high at an edge, the timeout count returns to zero and `rst_n_out` is low after that edge. An `osc_tick` sampled at the same edge is not counted.
- R4: `pll_tick` never advances the timeout, whatever the value of `src_sel`.
- R5: After release, `bus_en` pulses high for one cycle after every fourth selected tick. The phase count starts at zero on release, so the first pulse follows the fourth selected tick after release.
- R6: The selected source is `pll_tick` when the latched select is 1 and `osc_tick` when it is 0.
- R7: `src_sel` is latched on every edge while the block is held or being restarted, and otherwise only at the edge that completes a divide-by-four group. A change between boundaries has no effect until the next boundary.
- R8: `release_pulse` is high for exactly one cycle, and that cycle is the first one in which `rst_n_out` reads high.
- R9: While `rst` is applied, `rst_n_out`, `bus_en` and `release_pulse` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock carrying both tick enables |
| rst | input | 1 | Synchronous active-high reset, acts as a reset request |
| por_req | input | 1 | Power-on reset request |
| lvi_req | input | 1 | Low-voltage reset request |
| osc_tick | input | 1 | Oscillator reference tick enable |
| pll_tick | input | 1 | PLL tick enable |
| src_sel | input | 1 | Source select, 1 = PLL, 0 = oscillator |
| rst_n_out | output | 1 | Active-low reset output, low during timeout |
| bus_en | output | 1 | Bus-clock enable strobe, one per four selected ticks |
| release_pulse | output | 1 | One-cycle strobe when the timeout completes |

## Verification
The assertions assume that the ticks and requests are synchronous single-cycle enables in the `clk` domain. They also assume `rst` is high at the first edge. The stimulus produces ticks from periodic patterns computed from a cycle count and drives every input at the falling edge. It asserts `rst` before anything else. A bench model tracks the held state, the timeout tick count, the latched select and the position within the phase group, using only the requirements. The sweeps cover every combination of oscillator and PLL period from 1 to 4 with both select values. They also cover requests landing at each offset of a timeout, including the final tick, and a select that toggles between boundaries.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic {
    SRC_OSC = 1'b0,
    SRC_PLL = 1'b1
  } src_e;

  localparam int unsigned BUS_DIV_DEFAULT = 4;
  localparam int unsigned TIMEOUT_DEFAULT = 4096;
endpackage

// File: rtl/bcs_timeout.sv
module bcs_timeout #(
  parameter int unsigned TIMEOUT = bcs_pkg::TIMEOUT_DEFAULT
) (
  input  logic clk,
  input  logic rst,
  input  logic req,
  input  logic osc_tick,
  output logic held,
  output logic release_pulse
);
  localparam int unsigned CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

  logic [CW-1:0] cnt;
  logic          restart;

  assign restart = rst | req;

  always_ff @(posedge clk) begin
    if (restart) begin
      cnt           <= '0;
      held          <= 1'b1;
      release_pulse <= 1'b0;
    end else begin
      release_pulse <= 1'b0;
      if (held && osc_tick) begin
        if (cnt == LAST) begin
          cnt           <= '0;
          held          <= 1'b0;
          release_pulse <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R3: a request always leaves the block held
  p_hold_after_req_r3: assert property (@(posedge clk) disable iff (rst)
    req |=> held);

  // R8: release strobe lasts one cycle and coincides with leaving hold
  p_release_single_r8: assert property (@(posedge clk) disable iff (rst)
    release_pulse |=> !release_pulse);
  p_release_edge_r8: assert property (@(posedge clk) disable iff (rst)
    release_pulse |-> (!held && $past(held)));

  // R1: leaving hold needs an oscillator tick at the previous edge
  p_release_on_tick_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(held) |-> $past(osc_tick));
endmodule

// File: rtl/bcs_phase_div.sv
module bcs_phase_div #(
  parameter int unsigned DIV = bcs_pkg::BUS_DIV_DEFAULT
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic held,
  input  logic osc_tick,
  input  logic pll_tick,
  input  logic src_sel,
  output logic bus_en
);
  import bcs_pkg::*;

  localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] PLAST = PW'(DIV - 1);

  logic [PW-1:0] phase;
  src_e          sel_q;
  logic          tick;
  logic          clear;

  assign clear = restart | held;
  assign tick  = (sel_q == SRC_PLL) ? pll_tick : osc_tick;

  always_ff @(posedge clk) begin
    if (clear) begin
      phase  <= '0;
      sel_q  <= src_e'(src_sel);
      bus_en <= 1'b0;
    end else begin
      bus_en <= 1'b0;
      if (tick) begin
        if (phase == PLAST) begin
          phase  <= '0;
          bus_en <= 1'b1;
          sel_q  <= src_e'(src_sel);
        end else begin
          phase <= phase + 1'b1;
        end
      end
    end
  end

  // R2: no strobe while held
  p_no_en_held_r2: assert property (@(posedge clk) disable iff (rst)
    held |-> !bus_en);

  // R5: strobes are separated by at least one idle cycle
  p_en_spacing_r5: assert property (@(posedge clk) disable iff (rst)
    bus_en |=> !bus_en);

  // R7: latched select moves only on a boundary or while cleared
  p_sel_boundary_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(sel_q) |-> (bus_en || $past(clear)));
endmodule

// File: rtl/bus_clk_seq.sv
module bus_clk_seq #(
  parameter int unsigned TIMEOUT = bcs_pkg::TIMEOUT_DEFAULT,
  parameter int unsigned DIV     = bcs_pkg::BUS_DIV_DEFAULT
) (
  input  logic clk,
  input  logic rst,
  input  logic por_req,
  input  logic lvi_req,
  input  logic osc_tick,
  input  logic pll_tick,
  input  logic src_sel,
  output logic rst_n_out,
  output logic bus_en,
  output logic release_pulse
);
  logic req;
  logic held;

  assign req = por_req | lvi_req;

  bcs_timeout #(.TIMEOUT(TIMEOUT)) u_timeout (
    .clk          (clk),
    .rst          (rst),
    .req          (req),
    .osc_tick     (osc_tick),
    .held         (held),
    .release_pulse(release_pulse)
  );

  bcs_phase_div #(.DIV(DIV)) u_div (
    .clk     (clk),
    .rst     (rst),
    .restart (rst | req),
    .held    (held),
    .osc_tick(osc_tick),
    .pll_tick(pll_tick),
    .src_sel (src_sel),
    .bus_en  (bus_en)
  );

  assign rst_n_out = ~held;

  // R9/R3: reset output low after any reset cause
  p_low_after_rst_r9: assert property (@(posedge clk)
    rst |=> !rst_n_out);
endmodule

// File: tb/bus_clk_seq_bench.sv
module bus_clk_seq_bench;
  localparam int T   = 16;
  localparam int DIV = 4;

  logic clk = 1'b0;
  logic rst = 1'b1, por_req = 1'b0, lvi_req = 1'b0;
  logic osc_tick = 1'b0, pll_tick = 1'b0, src_sel = 1'b0;
  logic rst_n_out, bus_en, release_pulse;

  bus_clk_seq #(.TIMEOUT(T), .DIV(DIV)) u_bus_clk_seq (
    .clk(clk), .rst(rst), .por_req(por_req), .lvi_req(lvi_req),
    .osc_tick(osc_tick), .pll_tick(pll_tick), .src_sel(src_sel),
    .rst_n_out(rst_n_out), .bus_en(bus_en), .release_pulse(release_pulse)
  );

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  int cyc = 0, osc_per = 1, pll_per = 1;
  int held_cnt = 0, tick_cnt = 0, n_en = 0, n_rel = 0;
  bit eff_sel = 1'b0, sel_var = 1'b0, prev_rn = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic step(input bit r, input bit p, input bit l);
    bit o, q;
    @(negedge clk);
    if (!rst_n_out) chk(bus_en == 1'b0, "R2", bus_en, 0);
    if (rst_n_out && !prev_rn) begin
      chk(held_cnt == T, eff_sel ? "R4" : "R1", held_cnt, T);
      chk(release_pulse == 1'b1, "R8", release_pulse, 1);
      n_rel++;
      tick_cnt = 0;
    end else begin
      chk(release_pulse == 1'b0, "R8", release_pulse, 0);
    end
    if (rst_n_out) begin
      chk(bus_en == (tick_cnt == DIV), "R5/R6/R7", bus_en, int'(tick_cnt == DIV));
      if (bus_en) n_en++;
      if (tick_cnt >= DIV) tick_cnt = 0;
    end
    prev_rn = rst_n_out;
    o = (cyc % osc_per) == 0;
    q = ((cyc + 1) % pll_per) == 0;
    cyc++;
    osc_tick = o; pll_tick = q; src_sel = sel_var;
    rst = r; por_req = p; lvi_req = l;
    if (r || p || l) begin
      held_cnt = 0; tick_cnt = 0; eff_sel = sel_var;
    end else if (!rst_n_out) begin
      if (o) held_cnt++;
      eff_sel = sel_var;
    end else if (eff_sel ? q : o) begin
      tick_cnt++;
      if (tick_cnt == DIV) eff_sel = sel_var;
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    int wd = 0;
    while (wd < 190000) begin
      @(posedge clk);
      wd++;
    end
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=finish", wd);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    @(negedge clk);
    chk(rst_n_out == 1'b0, "R9", rst_n_out, 0);
    chk(bus_en == 1'b0, "R9", bus_en, 0);
    chk(release_pulse == 1'b0, "R9", release_pulse, 0);
    run(80);

    // R4/R6 sweep over source periods and select
    for (int op = 1; op <= 4; op++)
      for (int pp = 1; pp <= 4; pp++)
        for (int s = 0; s < 2; s++) begin
          osc_per = op; pll_per = pp; sel_var = s[0];
          step(1'b0, 1'b1, 1'b0);
          run(T * op + 60);
        end

    // R3: requests at every offset across a timeout, incl. the last tick
    osc_per = 1; pll_per = 2; sel_var = 1'b0;
    for (int d = 0; d <= T + 12; d++) begin
      step(1'b0, 1'b1, 1'b0);
      run(d);
      step(1'b0, 1'b0, 1'b1);
      run(T + 12);
    end

    // R7: select toggling between boundaries
    osc_per = 1; pll_per = 3;
    step(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 300; i++) begin
      if (i % 3 == 0) sel_var = ~sel_var;
      step(1'b0, 1'b0, 1'b0);
    end

    chk(n_rel > 0, "R8", n_rel, 1);
    chk(n_en > 0, "R5", n_en, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule